// File: doc/BRIEF.md
# Framed Register-Write Command Decoder

The decoder sits behind a host serial receiver and turns its byte stream into register writes. It waits for a fixed five-byte start sequence, 0x40 0x4C 0x44 0x53 0x7E. It then pairs the bytes that follow into 16-bit command words, high byte first, until a lone 0x7E closes the frame. Each word packs a 4-bit register address and an 8-bit value. The value is split across the word, and two of its bits are repeated in inverted form. The decoder unscrambles the word and tests those copies. For every good word it pulses a single-cycle write strobe with the address and data.

One control register, whose address is a parameter, carries a 2-bit bank field. When the last accepted write to that register set the bank field to the alternate code, writes to a parameterised address window are flagged for the alternate bank. Writing the control register again with another bank code restores normal decoding. Words that fail the integrity test are discarded and latch a sticky error flag, which only reset clears.

Top module: `frame_cmd_decoder`

## Requirements
- R1: After reset, wr_en, wr_alt_bank and word_err are 0, and the decoder is hunting for a start sequence with the bank field at 0.
- R2: Payload words are decoded only after the exact byte sequence 0x40, 0x4C, 0x44, 0x53, 0x7E. Bytes received while hunting never produce a strobe.
- R3: Word bits [11:8] give wr_addr. wr_data[5:0] comes from word bits [5:0], and wr_data[7:6] from word bits [13:12]. The high byte holds word bits [15:8].
- R4: A frame may hold any number of words. Each good word gives exactly one strobe, and the strobes come in the order the words arrived.
- R5: A word with bit 6 equal to bit 5, or with bit 14 equal to bit 13, gives no strobe and sets word_err. word_err stays 1 until reset, and later good words are still written.
- R6: A word with bit 7 or bit 15 set gives no strobe and sets word_err.
- R7: A 0x7E byte in place of a word's high byte ends the frame. Bytes after it produce no strobe until a new start sequence arrives.
- R8: A 0x7E byte in place of a word's low byte drops the partial word without setting word_err and returns the decoder to hunting.
- R9: A byte that breaks a partly matched start sequence restarts matching. If that byte is 0x40, it counts as the first start byte.
- R10: Suppose the last accepted write to address CTL2_ADDR (default 0xA) carried ALT_BANK (default 2) in value bits [BANK_LSB+1:BANK_LSB] (default [5:4]). Then strobes for addresses ALT_LO..ALT_HI (default 1..9) carry wr_alt_bank = 1. In every other case wr_alt_bank is 0.
- R11: The strobe is high for exactly the one cycle after the clock edge that takes in the word's low byte. Its address, data and bank flag are valid in that cycle.
- R12: A cycle with rx_valid low changes nothing, and it is followed by a cycle with wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register address of the write |
| wr_data | output | 8 | Unscrambled value of the write |
| wr_alt_bank | output | 1 | Write is steered to the alternate bank |
| word_err | output | 1 | Sticky flag: an integrity-failed word was dropped |

## Verification
Every result comes one clock edge after the byte that causes it. The strobe, address, data, bank flag and error flag all change at the edge that takes in a word's low byte. A high byte, header byte or terminator changes no output. The bench drives each byte at a falling edge and samples the outputs at the next falling edge. There it expects the strobe to be low after a high byte and to match its own decoding after a low byte. Idle cycles, with random data on the byte lines, are sampled at falling edges too, and the bench expects the strobe to be low in each of them. The bench also keeps its own copy of the bank field and of the error flag, and updates each one in the same byte step in which the decoder should.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int unsigned HDR_LEN   = 5;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned IDX_W     = $clog2(HDR_LEN);
    localparam logic [7:0]  TERM_BYTE = 8'h7E;

    typedef enum logic {SYNC_HUNT, SYNC_BODY} sync_e;

    function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] idx);
        case (idx)
            0:       return 8'h40;
            1:       return 8'h4C;
            2:       return 8'h44;
            3:       return 8'h53;
            default: return 8'h7E;
        endcase
    endfunction

    typedef struct packed {
        sync_e             st;
        logic [IDX_W-1:0]  idx;
        logic              phase;
        logic [7:0]        hi;
    } framer_s;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              alt;
        logic              err;
    } wr_out_s;
endpackage

// File: rtl/fcd_framer.sv
module fcd_framer
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              word_fire,
    output logic [WORD_W-1:0] word
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_LEN - 1);

    framer_s fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        word_fire = 1'b0;
        word      = {fr_q.hi, in_byte};
        if (in_valid) begin
            case (fr_q.st)
                SYNC_HUNT: begin
                    if (in_byte == hdr_byte(fr_q.idx)) begin
                        if (fr_q.idx == LAST_IDX) begin
                            fr_d.st    = SYNC_BODY;
                            fr_d.idx   = '0;
                            fr_d.phase = 1'b0;
                        end else begin
                            fr_d.idx = fr_q.idx + 1'b1;
                        end
                    end else if (in_byte == hdr_byte('0)) begin
                        fr_d.idx = IDX_W'(1);
                    end else begin
                        fr_d.idx = '0;
                    end
                end
                default: begin
                    if (in_byte == TERM_BYTE) begin
                        fr_d.st    = SYNC_HUNT;
                        fr_d.idx   = '0;
                        fr_d.phase = 1'b0;
                    end else if (!fr_q.phase) begin
                        fr_d.hi    = in_byte;
                        fr_d.phase = 1'b1;
                    end else begin
                        fr_d.phase = 1'b0;
                        word_fire  = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q <= '{st: SYNC_HUNT, idx: '0, phase: 1'b0, hi: '0};
        end else begin
            fr_q <= fr_d;
        end
    end
endmodule

// File: rtl/fcd_word_check.sv
module fcd_word_check
    import fcd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] value,
    output logic              ok
);
    always_comb begin
        addr  = word[11:8];
        value = {word[13:12], word[5:0]};
        ok    = !word[15] && !word[7] &&
                (word[14] != word[13]) && (word[6] != word[5]);
    end
endmodule

// File: rtl/fcd_bank_track.sv
module fcd_bank_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic [1:0] field,
    output logic [1:0] bank
);
    logic [1:0] bank_d, bank_q;

    always_comb begin
        bank_d = upd ? field : bank_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank = bank_q;
endmodule

// File: rtl/frame_cmd_decoder.sv
module frame_cmd_decoder
    import fcd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTL2_ADDR = 4'hA,
    parameter int unsigned       BANK_LSB  = 4,
    parameter logic [1:0]        ALT_BANK  = 2'd2,
    parameter logic [ADDR_W-1:0] ALT_LO    = 4'h1,
    parameter logic [ADDR_W-1:0] ALT_HI    = 4'h9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_alt_bank,
    output logic              word_err
);
    logic              fire;
    logic [WORD_W-1:0] word;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_value;
    logic              dec_ok;
    logic [1:0]        bank;
    logic              bank_upd;
    wr_out_s           out_d, out_q;

    fcd_framer i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_byte   (rx_byte),
        .word_fire (fire),
        .word      (word)
    );

    fcd_word_check i_check (
        .word  (word),
        .addr  (dec_addr),
        .value (dec_value),
        .ok    (dec_ok)
    );

    assign bank_upd = fire && dec_ok && (dec_addr == CTL2_ADDR);

    fcd_bank_track i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (bank_upd),
        .field (dec_value[BANK_LSB +: 2]),
        .bank  (bank)
    );

    always_comb begin
        out_d     = out_q;
        out_d.en  = fire && dec_ok;
        out_d.err = out_q.err || (fire && !dec_ok);
        if (fire && dec_ok) begin
            out_d.addr = dec_addr;
            out_d.data = dec_value;
            out_d.alt  = (bank == ALT_BANK) &&
                         (dec_addr >= ALT_LO) && (dec_addr <= ALT_HI);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_en       = out_q.en;
    assign wr_addr     = out_q.addr;
    assign wr_data     = out_q.data;
    assign wr_alt_bank = out_q.en && out_q.alt;
    assign word_err    = out_q.err;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter logic [3:0] ALT_LO = 4'h1,
    parameter logic [3:0] ALT_HI = 4'h9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic       wr_alt_bank,
    input logic       word_err
);
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_err |=> word_err);

    assert_drop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_err) |-> !wr_en);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !wr_en);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_alt_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_alt_bank |-> (wr_en && wr_addr >= ALT_LO && wr_addr <= ALT_HI));
endmodule

bind frame_cmd_decoder fcd_checker #(
    .ALT_LO (ALT_LO),
    .ALT_HI (ALT_HI)
) i_fcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_alt_bank (wr_alt_bank),
    .word_err    (word_err)
);

// File: tb/test_frame_cmd_decoder.sv
module test_frame_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] CTL2 = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       wr_alt_bank;
    logic       word_err;

    int   total = 0;
    int   bad = 0;
    logic exp_err = 1'b0;
    logic [1:0] bank_m = 2'd0;
    int   seed_sink;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_cmd_decoder i_frame_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_alt_bank(wr_alt_bank), .word_err(word_err)
    );

    function automatic logic [15:0] enc(input logic [3:0] a, input logic [7:0] v);
        return {1'b0, ~v[7], v[7:6], a, 1'b0, ~v[5], v[5:0]};
    endfunction

    function automatic logic good(input logic [15:0] w);
        return !w[15] && !w[7] && (w[14] != w[13]) && (w[6] != w[5]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_err = 1'b0; bank_m = 2'd0;
    endtask

    // drive one byte at a falling edge; return at the next falling edge
    task automatic put(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_byte = 8'($urandom);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b0; rx_byte = 8'($urandom);
            @(negedge clk);
            chk("R12 idle strobe", wr_en, 0);
        end
    endtask

    task automatic header();
        put(8'h40); put(8'h4C); put(8'h44); put(8'h53); put(8'h7E);
        chk("R2 no strobe in header", wr_en, 0);
    endtask

    // send one word; in_frame tells whether the decoder should be in a frame
    task automatic send_w(input logic [15:0] w, input logic in_frame, input int gap);
        logic en_e, alt_e;
        logic [3:0] a;
        logic [7:0] v;
        a = w[11:8];
        v = {w[13:12], w[5:0]};
        put(w[15:8]);
        chk("R11 no strobe after high byte", wr_en, 0);
        if (gap > 0) idle(gap);
        put(w[7:0]);
        en_e  = in_frame && good(w);
        alt_e = en_e && (bank_m == 2'd2) && (a >= 4'h1) && (a <= 4'h9);
        if (in_frame && !good(w)) exp_err = 1'b1;
        chk(in_frame ? "R4 R5 R6 strobe" : "R2 R7 R8 no strobe outside frame", wr_en, en_e);
        if (en_e) begin
            chk("R3 addr", wr_addr, a);
            chk("R3 data", wr_data, v);
            chk("R10 alt bank", wr_alt_bank, alt_e);
            if (a == CTL2) bank_m = v[5:4];
        end
        chk("R5 R6 word_err", word_err, exp_err);
    endtask

    task automatic run_all();
        logic [15:0] w;
        do_reset();
        @(negedge clk);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 alt", wr_alt_bank, 0);
        chk("R1 err", word_err, 0);

        // R2 R3 R4: multi-word frame
        header();
        send_w(enc(4'h3, 8'hA5), 1, 0);
        send_w(enc(4'hC, 8'h7F), 1, 1);
        send_w(enc(4'h0, 8'hC0), 1, 0);
        put(8'h7E);
        chk("R7 terminator no strobe", wr_en, 0);
        // R7: after the terminator, bytes are ignored
        send_w(enc(4'h5, 8'h12), 0, 0);
        // R2: a broken header followed by words
        put(8'h40); put(8'h4C); put(8'h00);
        send_w(enc(4'h6, 8'h21), 0, 0);
        // R9: restart on 0x40 mid-header
        put(8'h40); put(8'h4C); put(8'h44); put(8'h40);
        put(8'h4C); put(8'h44); put(8'h53); put(8'h7E);
        send_w(enc(4'h7, 8'h3C), 1, 0);
        put(8'h7E);
        // R8: 0x7E on an odd boundary aborts
        header();
        put(8'h0B);
        put(8'h7E);
        chk("R8 odd terminator no strobe", wr_en, 0);
        chk("R8 no error", word_err, 0);
        send_w(enc(4'h2, 8'h01), 0, 0);
        // R10: bank switching
        header();
        send_w(enc(CTL2, 8'h20), 1, 0);
        send_w(enc(4'h3, 8'h55), 1, 0);
        send_w(enc(4'h9, 8'h01), 1, 0);
        send_w(enc(4'hB, 8'h02), 1, 0);
        send_w(enc(4'h0, 8'h03), 1, 0);
        send_w(enc(CTL2, 8'h00), 1, 0);
        send_w(enc(4'h3, 8'h55), 1, 0);
        put(8'h7E);
        // R5: bad check bit, then sticky flag and later good word
        header();
        w = enc(4'h3, 8'h15); w[6] = ~w[6];
        send_w(w, 1, 0);
        send_w(enc(4'h4, 8'h44), 1, 0);
        w = enc(4'h3, 8'h95); w[14] = ~w[14];
        send_w(w, 1, 0);
        put(8'h7E);
        // R6: reserved bits
        do_reset();
        header();
        send_w(enc(4'h2, 8'h01) | 16'h8000, 1, 0);
        do_reset();
        header();
        send_w(enc(4'h2, 8'h01) | 16'h0080, 1, 0);
        put(8'h7E);
        // random frames
        do_reset();
        for (int f = 0; f < 40; f++) begin
            int n;
            n = 1 + int'($urandom_range(0, 7));
            header();
            for (int k = 0; k < n; k++) begin
                logic [3:0] a;
                logic [7:0] v;
                a = 4'($urandom);
                v = 8'($urandom);
                if ($urandom_range(0, 5) == 0) v[5:4] = 2'd2;
                w = enc(a, v);
                if ($urandom_range(0, 9) == 0) begin
                    case ($urandom_range(0, 2))
                        0: w[15] = 1'b1;
                        1: w[7] = 1'b1;
                        default: w[6] = ~w[6];
                    endcase
                    if (w[15:8] == 8'h7E || w[7:0] == 8'h7E) w[15] = 1'b1;
                end
                send_w(w, 1, int'($urandom_range(0, 2)));
            end
            put(8'h7E);
            idle(int'($urandom_range(0, 3)));
        end
    endtask

    initial begin
        seed_sink = $urandom(32'd1234);
        @(negedge clk);
        fork
            run_all();
            begin
                #(CLK_PERIOD * 150000);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule